// File: doc/BRIEF.md
# Serial ADC Sample Reader

This block is a receive-only serial master for an 8-bit serial-output ADC. It divides a fast system clock down to produce the converter's serial clock. A frame counter steps once per serial clock period and drives an active-low chip select, which opens one conversion frame at a time. Inside each frame the counter also marks the short window where the eight conversion bits appear on the data line. Only those bits reach the result.

Every frame has the same layout. Three leading zero bits come first. The eight data bits follow, most significant first. Then come four trailing zeros and one bit during which the converter leaves the line floating. Chip select then stays high for the rest of the frame. When the last data bit has been captured, the assembled byte appears on the sample output together with a one-cycle valid strobe. Every register in the block runs on the system clock. The serial clock and all frame events come from clock enables.

Top module: `spi_adc_reader`

## Requirements
- R1: `sclk_o` changes level once every `DIV_HALF` system clock cycles (26 by default), so its high and low phases are equal. It is low in reset, and its first rising edge comes at the 26th rising `clk` edge after reset is released.
- R2: The frame counter advances once per rising edge of `sclk_o` and runs from 0 to `FRAME_LAST` (20). A complete frame therefore lasts 21 serial clock periods, measured between consecutive falling edges of `cs_n_o`.
- R3: After reset, `cs_n_o` stays high until the counter first wraps. From then on it goes low as the counter wraps to 0 and goes high again when the counter reaches `CS_HIGH_AT` (16). Both changes happen on the system clock edge that raises `sclk_o`.
- R4: The data line is sampled on rising edges of `sclk_o`. Call the first rising edge after `cs_n_o` falls frame bit 0. Only frame bits 3 to 10 are shifted in. The leading bits, the trailing bits and the floating bit 15 have no effect on `sample_o`, whatever level they carry.
- R5: The first captured data bit (frame bit 3) becomes bit 7 of `sample_o` and the last (frame bit 10) becomes bit 0.
- R6: `valid_o` is high for exactly one `clk` cycle per frame. It is asserted on the same edge that raises `sclk_o` for frame bit 10, and `sample_o` takes the new byte on that edge. At all other times `sample_o` holds its value.
- R7: A synchronous active-high `rst` clears the divider, the frame counter and the sample. While `rst` is high, `sclk_o` and `valid_o` are low, `cs_n_o` is high and `sample_o` is 0. After release the block starts again with a full idle frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| sdo_i | input | 1 | Serial data from the ADC, changed by the ADC on falling `sclk_o` |
| sclk_o | output | 1 | Serial clock to the ADC |
| cs_n_o | output | 1 | Active-low chip select to the ADC |
| sample_o | output | 8 | Last received sample, MSB first on the wire |
| valid_o | output | 1 | One-cycle strobe marking a new `sample_o` |

## Verification
The embedded assertions check the following on every cycle:
- the counter never leaves its 0 to 20 range and wraps to 0;
- chip select rises only at count 16 and falls only at the wrap;
- the serial clock holds between divider terminal counts;
- the shift register moves only inside the data window;
- the valid strobe never lasts two cycles and the sample never moves without it.

Only the bench's scenarios can show the rest. These are that the bytes come out in the right bit order and that junk driven on the leading, trailing and floating bits is rejected. The bench also confirms the exact edge at which each output changes relative to reset, and that a reset in the middle of a frame restarts with an idle frame.

// File: rtl/spi_adc_pkg.sv
package spi_adc_pkg;

  // Default timing of one conversion frame, in serial clock periods.
  localparam int DEF_DIV_HALF   = 26;  // system cycles per serial clock half period
  localparam int DEF_FRAME_LAST = 20;  // last frame counter value before wrap
  localparam int DEF_CS_HIGH_AT = 16;  // counter value that deselects the ADC
  localparam int DEF_LEAD_BITS  = 3;   // zero bits ahead of the data
  localparam int DEF_DATA_BITS  = 8;   // sample width

  // Where the frame counter currently sits inside a frame.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // chip select high
    PH_LEAD = 2'd1,  // leading zeros
    PH_DATA = 2'd2,  // sample bits
    PH_TAIL = 2'd3   // trailing zeros and floating bit
  } frame_phase_t;

endpackage

// File: rtl/spi_adc_sclk_gen.sv
module spi_adc_sclk_gen #(
  parameter int DIV_HALF = 26
) (
  input  logic clk,
  input  logic rst,
  output logic sclk_o,
  output logic rise_o
);

  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(DIV_HALF - 1);

  logic [DIV_W-1:0] div_q;
  logic             sclk_q;
  logic             tick;

  assign tick   = (div_q == DIV_TOP);
  assign rise_o = tick && !sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      div_q  <= '0;
      sclk_q <= !sclk_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  // R1
  sclk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (div_q != DIV_TOP) |=> $stable(sclk_q));

  // R1
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    div_q <= DIV_TOP);

  // R7
  sclk_reset_chk: assert property (@(posedge clk)
    rst |=> !sclk_q);

endmodule

// File: rtl/spi_adc_frame_seq.sv
module spi_adc_frame_seq
  import spi_adc_pkg::*;
#(
  parameter int FRAME_LAST = 20,
  parameter int CS_HIGH_AT = 16,
  parameter int LEAD_BITS  = 3,
  parameter int DATA_BITS  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  output logic cs_n_o,
  output logic cap_o,
  output logic done_o
);

  localparam int CNT_W = $clog2(FRAME_LAST + 1);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(FRAME_LAST);
  localparam logic [CNT_W-1:0] CSHI_C  = CNT_W'(CS_HIGH_AT);
  localparam logic [CNT_W-1:0] DFST_C  = CNT_W'(LEAD_BITS);
  localparam logic [CNT_W-1:0] DLST_C  = CNT_W'(LEAD_BITS + DATA_BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             cs_n_q;
  frame_phase_t     phase;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    if (cs_n_q)               phase = PH_IDLE;
    else if (cnt_q < DFST_C)  phase = PH_LEAD;
    else if (cnt_q <= DLST_C) phase = PH_DATA;
    else                      phase = PH_TAIL;
  end

  assign cap_o  = step_i && (phase == PH_DATA);
  assign done_o = cap_o && (cnt_q == DLST_C);
  assign cs_n_o = cs_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      cs_n_q <= 1'b1;
    end else if (step_i) begin
      if (cnt_q == LAST_C) begin
        cnt_q  <= '0;
        cs_n_q <= 1'b0;
      end else begin
        cnt_q <= cnt_inc;
        if (cnt_inc == CSHI_C) cs_n_q <= 1'b1;
      end
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_C);

  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && cnt_q == LAST_C) |=> (cnt_q == '0));

  // R3
  cs_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_q) |-> (cnt_q == CSHI_C));

  // R3
  cs_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_q) |-> (cnt_q == '0));

endmodule

// File: rtl/spi_adc_rx_shift.sv
module spi_adc_rx_shift #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cap_i,
  input  logic                 done_i,
  input  logic                 sdo_i,
  output logic [DATA_BITS-1:0] sample_o,
  output logic                 valid_o
);

  logic [DATA_BITS-1:0] shift_q;
  logic [DATA_BITS-1:0] shift_nxt;

  assign shift_nxt = {shift_q[DATA_BITS-2:0], sdo_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q  <= '0;
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap_i) shift_q <= shift_nxt;
      if (done_i) begin
        sample_o <= shift_nxt;
        valid_o  <= 1'b1;
      end
    end
  end

  // R4
  shift_window_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_i |=> $stable(shift_q));

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R6
  sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(sample_o));

endmodule

// File: rtl/spi_adc_reader.sv
module spi_adc_reader
  import spi_adc_pkg::*;
#(
  parameter int DIV_HALF   = DEF_DIV_HALF,
  parameter int FRAME_LAST = DEF_FRAME_LAST,
  parameter int CS_HIGH_AT = DEF_CS_HIGH_AT,
  parameter int LEAD_BITS  = DEF_LEAD_BITS,
  parameter int DATA_BITS  = DEF_DATA_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sdo_i,
  output logic                 sclk_o,
  output logic                 cs_n_o,
  output logic [DATA_BITS-1:0] sample_o,
  output logic                 valid_o
);

  logic sclk_rise;
  logic cap;
  logic done;

  spi_adc_sclk_gen #(
    .DIV_HALF (DIV_HALF)
  ) u_sclk (
    .clk    (clk),
    .rst    (rst),
    .sclk_o (sclk_o),
    .rise_o (sclk_rise)
  );

  spi_adc_frame_seq #(
    .FRAME_LAST (FRAME_LAST),
    .CS_HIGH_AT (CS_HIGH_AT),
    .LEAD_BITS  (LEAD_BITS),
    .DATA_BITS  (DATA_BITS)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .step_i (sclk_rise),
    .cs_n_o (cs_n_o),
    .cap_o  (cap),
    .done_o (done)
  );

  spi_adc_rx_shift #(
    .DATA_BITS (DATA_BITS)
  ) u_rx (
    .clk      (clk),
    .rst      (rst),
    .cap_i    (cap),
    .done_i   (done),
    .sdo_i    (sdo_i),
    .sample_o (sample_o),
    .valid_o  (valid_o)
  );

  // R7
  reset_outputs_chk: assert property (@(posedge clk)
    rst |=> (cs_n_o && !valid_o && sample_o == '0));

  // R6
  valid_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> sclk_o);

endmodule

// File: tb/spi_adc_reader_tb.sv
module spi_adc_reader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 26;
  localparam int FRAME      = 21;
  localparam int CS_HI      = 16;
  localparam int LEAD       = 3;
  localparam int LAST_DATA  = 10;
  localparam int RUN_CYCLES = 2 * HALF * FRAME * 8;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sdo = 1'b0;
  logic       sclk;
  logic       cs_n;
  logic [7:0] sample;
  logic       valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_adc_reader u_dut (
    .clk      (clk),
    .rst      (rst),
    .sdo_i    (sdo),
    .sclk_o   (sclk),
    .cs_n_o   (cs_n),
    .sample_o (sample),
    .valid_o  (valid)
  );

  int compared   = 0;
  int mismatched = 0;
  bit done_run   = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s at %0t: actual=%0d expected=%0d", tag, what, $time, act, exp);
    end
  endtask

  // Stimulus bytes, cycled through frame by frame
  logic [7:0] pat [12] = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'hA5, 8'h5A,
                           8'h3C, 8'hC3, 8'h7E, 8'h81, 8'h55, 8'hAA};

  function automatic logic adc_bit(input int idx, input logic [7:0] d, input bit junk);
    if (idx < LEAD)       return junk;
    if (idx <= LAST_DATA) return d[LAST_DATA - idx];
    if (idx < CS_HI - 1)  return junk;
    return 1'b1;  // floating bit and beyond
  endfunction

  // Reference model state
  int         n;
  logic [8:0] expq [$];
  logic [7:0] ref_sample;
  bit         ref_junk;
  int         dut_valids, ref_valids;
  // ADC model state
  logic       prev_cs, prev_sclk;
  int         idx, fi, rises;
  bit         seen_fall, cur_junk;
  logic [7:0] cur_byte;

  initial begin
    n = 0; ref_sample = '0; ref_junk = 1'b0; dut_valids = 0; ref_valids = 0;
    prev_cs = 1'b1; prev_sclk = 1'b0; idx = 99; fi = 0; rises = 0;
    seen_fall = 1'b0; cur_junk = 1'b0; cur_byte = '0;
  end

  always @(negedge clk) begin
    logic e_sclk, e_cs, e_valid;
    int   r_done, r_idx;
    string ts;
    if (rst) begin
      n = 0;
      e_sclk = 1'b0; e_cs = 1'b1; e_valid = 1'b0;
      ref_sample = '0;
      expq.delete();
      prev_cs = 1'b1; prev_sclk = 1'b0; idx = 99; rises = 0; seen_fall = 1'b0;
      sdo = 1'b0;
      // R7: reset state
      chk(sclk == 1'b0, "R7", "sclk in reset", int'(sclk), 0);
      chk(cs_n == 1'b1, "R7", "cs_n in reset", int'(cs_n), 1);
      chk(valid == 1'b0, "R7", "valid in reset", int'(valid), 0);
      chk(sample == 8'h00, "R7", "sample in reset", int'(sample), 0);
    end else begin
      n++;
      e_sclk = ((n / HALF) % 2) == 1;
      r_done = (n + HALF) / (2 * HALF);
      e_cs   = !(r_done >= FRAME && (r_done % FRAME) < CS_HI);
      r_idx  = n / (2 * HALF);
      e_valid = (n % (2 * HALF) == HALF) && (r_idx >= FRAME) && (r_idx % FRAME == LAST_DATA);
      if (e_valid) begin
        ref_valids++;
        if (expq.size() > 0) begin
          logic [8:0] ent;
          ent = expq.pop_front();
          ref_junk   = ent[8];
          ref_sample = ent[7:0];
        end
      end
      if (valid) dut_valids++;
      // R1: serial clock level
      chk(sclk == e_sclk, "R1", "sclk", int'(sclk), int'(e_sclk));
      // R3: chip select level
      chk(cs_n == e_cs, "R3", "cs_n", int'(cs_n), int'(e_cs));
      // R6: valid strobe timing
      chk(valid == e_valid, "R6", "valid", int'(valid), int'(e_valid));
      // R5 (clean frames) / R4 (frames with junk around the window)
      ts = ref_junk ? "R4" : "R5";
      chk(sample == ref_sample, ts, "sample", int'(sample), int'(ref_sample));

      // ADC model, reacting to the DUT's outputs
      if (!prev_sclk && sclk) rises++;
      if (prev_cs && !cs_n) begin
        // R2: frame length in serial clock periods
        if (seen_fall) chk(rises == FRAME, "R2", "sclk periods per frame", rises, FRAME);
        seen_fall = 1'b1;
        rises = 0;
        cur_byte = pat[fi % 12];
        cur_junk = fi[0];
        expq.push_back({cur_junk, cur_byte});
        fi++;
        idx = -1;
      end else if (prev_sclk && !sclk && !cs_n) begin
        idx++;
      end
      if (idx < 0) sdo = cur_junk;
      else sdo = adc_bit(idx, cur_byte, cur_junk);
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    repeat (RUN_CYCLES) @(negedge clk);
    // reset in the middle of a frame
    repeat (700) @(negedge clk);
    #1 rst = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    repeat (RUN_CYCLES) @(negedge clk);
    #1;
    // R6: one strobe per frame overall
    chk(dut_valids == ref_valids, "R6", "valid pulse count", dut_valids, ref_valids);
    chk(ref_valids >= 12, "R6", "frames completed", ref_valids, 12);
    done_run = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done_run) begin
      compared++;
      mismatched++;
      $display("FAIL R6 watchdog expired: actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule